// File: doc/BRIEF.md
# Selectable-Rate Digital De-emphasis Filter

This block takes a stream of signed 24-bit audio words over a valid/ready handshake. It returns each word either unchanged or passed through a first-order shelving filter. The filter corner time constants are 50 µs (pole) and 15 µs (zero). Its gain is unity at DC and falls toward about -10 dB at high frequency. The filter runs as a direct-form I recursion with one zero and one pole. Its coefficients are fixed-point constants with 22 fractional bits, and one set is stored for each supported sample rate: 32 kHz, 44.1 kHz and 48 kHz.

A 3-bit mode input selects where the enable comes from: a software bit, a dedicated pin, or an emphasis flag decoded upstream from received channel-status data. In the channel-status mode the sample-rate code also comes from that data. A width-select input chooses between filtering the whole word and filtering only the upper 20 bits. In the 20-bit case the four low auxiliary bits are carried through untouched. The enable, rate and width settings are captured together with each sample, so a change of configuration always takes effect at a sample boundary.

Top module: `deemph_filter`

## Requirements
- R1: While reset is high and in the cycle after it, `m_valid` is 0 and `s_ready` is 1.
- R2: Only one sample is in flight at a time. After an input handshake `s_ready` stays low until the result has been taken. While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold steady.
- R3: When the selected enable is off, `m_data` equals the accepted word bit for bit, and the filter history is cleared. The first filtered result after the enable returns therefore depends only on the current input.
- R4: When enabled, the filter computes y = clamp((b0·v + b1·v_prev + c1·y_prev + 2^21) >> 22), using an arithmetic shift. v is the filter input and v_prev, y_prev are the previous input and output. The result is clamped to the signed range of the active width.
- R5: Rate code 0 selects 44.1 kHz (b0=1800992, b1=-250418, c1=2643730). Code 1 selects 48 kHz (b0=1764500, b1=-318189, c1=2747992). Code 2 selects 32 kHz (b0=1957342, b1=39946, c1=2197016).
- R6: Mode values 0 to 3 take the enable from `sw_emph`. Mode values 4 to 6 take it from `pin_emph`. Modes 0 to 6 take the rate from `rate_sel`.
- R7: Mode 7 enables filtering when `cs_valid` and `cs_emph` are both 1, and then uses `cs_rate` as the rate code. When no rate information is available, the 44.1 kHz set is used: either `cs_valid` is 0 or the code is 3.
- R8: With `aux_keep`=1, bits 23:4 are filtered as a signed 20-bit value clamped to 20 bits, and bits 3:0 are copied from the input. A change of `aux_keep` between enabled samples clears the history.
- R9: With `aux_keep`=0, all 24 bits are filtered.
- R10: The rate is sampled with each word. A rate change between enabled samples of the same width switches coefficients for that sample onward and keeps the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can accept a word |
| s_data | input | DW | Signed input audio word |
| emph_mode | input | 3 | Enable source select |
| sw_emph | input | 1 | Software enable bit |
| pin_emph | input | 1 | Hardware enable pin |
| rate_sel | input | 2 | Rate code used in modes 0 to 6 |
| cs_valid | input | 1 | Channel-status fields valid |
| cs_emph | input | 1 | Channel-status emphasis flag |
| cs_rate | input | 2 | Channel-status rate code |
| aux_keep | input | 1 | 1: filter upper 20 bits, keep low 4 bits |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts output |
| m_data | output | DW | Output audio word |

## Verification
Some rules can be checked on every cycle, and the assertions cover those: a single sample in flight, a result held stable under backpressure, low nibble pass-through in narrow mode, and bit-exact bypass when the software enable is off. Other behaviour only shows up across sequences of samples, and only the bench's scenarios can reveal it. This covers the numeric response for each coefficient set, the fall-back to 44.1 kHz, history clearing when the enable is dropped or the width changes, and history carried across a rate switch.

// File: rtl/deemph_pkg.sv
package deemph_pkg;
  localparam int COEF_W    = 24;
  localparam int COEF_FRAC = 22;

  localparam logic [1:0] RATE_44K1 = 2'd0;
  localparam logic [1:0] RATE_48K  = 2'd1;
  localparam logic [1:0] RATE_32K  = 2'd2;
  localparam logic [1:0] RATE_NONE = 2'd3;

  typedef struct packed {
    logic signed [COEF_W-1:0] b0;
    logic signed [COEF_W-1:0] b1;
    logic signed [COEF_W-1:0] c1;
  } coef_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_OUT} seq_e;
endpackage

// File: rtl/deemph_coef_rom.sv
module deemph_coef_rom
  import deemph_pkg::*;
(
  input  logic [1:0] rate,
  output coef_t      coef
);
  // Bilinear-mapped 50us/15us shelf, Q2.22
  always_comb begin
    case (rate)
      RATE_48K: begin
        coef.b0 = 24'sd1764500;
        coef.b1 = -24'sd318189;
        coef.c1 = 24'sd2747992;
      end
      RATE_32K: begin
        coef.b0 = 24'sd1957342;
        coef.b1 = 24'sd39946;
        coef.c1 = 24'sd2197016;
      end
      default: begin
        coef.b0 = 24'sd1800992;
        coef.b1 = -24'sd250418;
        coef.c1 = 24'sd2643730;
      end
    endcase
  end
endmodule

// File: rtl/deemph_src_sel.sv
module deemph_src_sel
  import deemph_pkg::*;
(
  input  logic [2:0] emph_mode,
  input  logic       sw_emph,
  input  logic       pin_emph,
  input  logic [1:0] rate_sel,
  input  logic       cs_valid,
  input  logic       cs_emph,
  input  logic [1:0] cs_rate,
  output logic       en,
  output logic [1:0] rate
);
  always_comb begin
    if (emph_mode == 3'd7) begin
      en   = cs_valid & cs_emph;
      rate = cs_valid ? cs_rate : RATE_NONE;
    end else if (emph_mode[2]) begin
      en   = pin_emph;
      rate = rate_sel;
    end else begin
      en   = sw_emph;
      rate = rate_sel;
    end
  end
endmodule

// File: rtl/deemph_core.sv
module deemph_core
  import deemph_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 4
) (
  input  logic signed [DW-1:0] x,
  input  logic                 narrow,
  input  logic signed [DW-1:0] x1,
  input  logic signed [DW-1:0] y1,
  input  coef_t                coef,
  output logic signed [DW-1:0] v,
  output logic signed [DW-1:0] q
);
  localparam int NW = DW - AW;
  localparam int PW = DW + COEF_W + 3;

  logic signed [PW-1:0] p_b0, p_b1, p_c1, acc, rnd, sh, hi, lo;

  always_comb begin
    v    = narrow ? {{AW{x[DW-1]}}, x[DW-1:AW]} : x;
    p_b0 = PW'(coef.b0) * PW'(v);
    p_b1 = PW'(coef.b1) * PW'(x1);
    p_c1 = PW'(coef.c1) * PW'(y1);
    acc  = p_b0 + p_b1 + p_c1;
    rnd  = acc + (PW'(1) <<< (COEF_FRAC - 1));
    sh   = rnd >>> COEF_FRAC;
    hi   = narrow ? ((PW'(1) <<< (NW - 1)) - PW'(1))
                  : ((PW'(1) <<< (DW - 1)) - PW'(1));
    lo   = -hi - PW'(1);
    if (sh > hi)      q = hi[DW-1:0];
    else if (sh < lo) q = lo[DW-1:0];
    else              q = sh[DW-1:0];
  end
endmodule

// File: rtl/deemph_filter.sv
module deemph_filter
  import deemph_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic [2:0]    emph_mode,
  input  logic          sw_emph,
  input  logic          pin_emph,
  input  logic [1:0]    rate_sel,
  input  logic          cs_valid,
  input  logic          cs_emph,
  input  logic [1:0]    cs_rate,
  input  logic          aux_keep,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  localparam int NW = DW - AW;

  seq_e                 st;
  logic                 sel_en;
  logic [1:0]           sel_rate;
  coef_t                rom_coef, coef_q;
  logic signed [DW-1:0] x_q, x1_q, y1_q, x1_use, y1_use, v_w, q_w;
  logic                 en_q, nar_q, hist_live, hist_nar, hist_ok;
  logic                 take;

  deemph_src_sel u_sel (
    .emph_mode(emph_mode), .sw_emph(sw_emph), .pin_emph(pin_emph),
    .rate_sel(rate_sel), .cs_valid(cs_valid), .cs_emph(cs_emph),
    .cs_rate(cs_rate), .en(sel_en), .rate(sel_rate)
  );

  deemph_coef_rom u_rom (.rate(sel_rate), .coef(rom_coef));

  assign hist_ok = hist_live && (hist_nar == nar_q);
  assign x1_use  = hist_ok ? x1_q : '0;
  assign y1_use  = hist_ok ? y1_q : '0;

  deemph_core #(.DW(DW), .AW(AW)) u_core (
    .x(x_q), .narrow(nar_q), .x1(x1_use), .y1(y1_use),
    .coef(coef_q), .v(v_w), .q(q_w)
  );

  assign s_ready = (st == ST_IDLE);
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      m_valid   <= 1'b0;
      m_data    <= '0;
      x_q       <= '0;
      en_q      <= 1'b0;
      nar_q     <= 1'b0;
      coef_q    <= '0;
      x1_q      <= '0;
      y1_q      <= '0;
      hist_live <= 1'b0;
      hist_nar  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          x_q    <= s_data;
          en_q   <= sel_en;
          nar_q  <= aux_keep;
          coef_q <= rom_coef;
          st     <= ST_CALC;
        end
        ST_CALC: begin
          if (en_q) begin
            m_data    <= nar_q ? {q_w[NW-1:0], x_q[AW-1:0]} : q_w;
            x1_q      <= v_w;
            y1_q      <= q_w;
            hist_live <= 1'b1;
            hist_nar  <= nar_q;
          end else begin
            m_data    <= x_q;
            x1_q      <= '0;
            y1_q      <= '0;
            hist_live <= 1'b0;
          end
          m_valid <= 1'b1;
          st      <= ST_OUT;
        end
        ST_OUT: if (m_ready) begin
          m_valid <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/deemph_filter_chk.sv
module deemph_filter_chk #(
  parameter int DW = 24,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_ready,
  input logic [DW-1:0] s_data,
  input logic [2:0]    emph_mode,
  input logic          sw_emph,
  input logic          aux_keep,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_data
);
  logic          pend_aux, pend_byp;
  logic [AW-1:0] pend_nib;
  logic [DW-1:0] pend_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_aux  <= 1'b0;
      pend_byp  <= 1'b0;
      pend_nib  <= '0;
      pend_word <= '0;
    end else if (s_valid && s_ready) begin
      pend_aux  <= aux_keep;
      pend_byp  <= !emph_mode[2] && !sw_emph;
      pend_nib  <= s_data[AW-1:0];
      pend_word <= s_data;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> !m_valid && s_ready);

  assert_one_in_flight_R2: assert property (@(posedge clk) disable iff (rst)
    s_valid && s_ready |=> !s_ready);

  assert_busy_while_out_R2: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> !s_ready);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) && pend_byp |-> m_data == pend_word);

  assert_aux_pass_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) && pend_aux |-> m_data[AW-1:0] == pend_nib);
endmodule

bind deemph_filter deemph_filter_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .s_data(s_data), .emph_mode(emph_mode), .sw_emph(sw_emph),
  .aux_keep(aux_keep), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data)
);

// File: tb/tb_deemph_filter.sv
module tb_deemph_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_data = '0;
  logic [2:0]  emph_mode = '0;
  logic        sw_emph = 1'b0, pin_emph = 1'b0;
  logic [1:0]  rate_sel = '0;
  logic        cs_valid = 1'b0, cs_emph = 1'b0;
  logic [1:0]  cs_rate = '0;
  logic        aux_keep = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [23:0] m_data;

  int total = 0, bad = 0, cyc = 0;
  logic bp = 1'b0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  longint h_x1 = 0, h_y1 = 0;
  bit     h_live = 0, h_nar = 0;

  always #10 clk = ~clk;

  deemph_filter dut (.*);

  always @(negedge clk) begin
    cyc++;
    m_ready <= bp ? (cyc[0] ^ cyc[2]) : 1'b1;
  end

  function automatic void coefs(input logic [1:0] r, output longint b0,
                                output longint b1, output longint c1);
    case (r)
      2'd1:    begin b0 = 1764500; b1 = -318189; c1 = 2747992; end
      2'd2:    begin b0 = 1957342; b1 = 39946;   c1 = 2197016; end
      default: begin b0 = 1800992; b1 = -250418; c1 = 2643730; end
    endcase
  endfunction

  task automatic send(input logic [23:0] x, input logic [2:0] md,
                      input bit sw, input bit pin, input logic [1:0] rs,
                      input bit csv, input bit cse, input logic [1:0] csr,
                      input bit nar, input string tag);
    bit en; logic [1:0] r; longint b0, b1, c1, v, acc, q, hi;
    logic [23:0] e;
    if (md == 3'd7) begin en = csv && cse; r = csv ? csr : 2'd3; end
    else if (md >= 3'd4) begin en = pin; r = rs; end
    else begin en = sw; r = rs; end
    if (!en) begin
      e = x; h_live = 0; h_x1 = 0; h_y1 = 0;
    end else begin
      coefs(r, b0, b1, c1);
      v = nar ? longint'(signed'(x[23:4])) : longint'(signed'(x));
      acc = b0 * v;
      if (h_live && h_nar == nar) acc += b1 * h_x1 + c1 * h_y1;
      q = (acc + 64'sd2097152) >>> 22;
      hi = nar ? 524287 : 8388607;
      if (q > hi) q = hi;
      if (q < -hi - 1) q = -hi - 1;
      e = nar ? {q[19:0], x[3:0]} : q[23:0];
      h_x1 = v; h_y1 = q; h_live = 1; h_nar = nar;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    s_data = x; emph_mode = md; sw_emph = sw; pin_emph = pin;
    rate_sel = rs; cs_valid = csv; cs_emph = cse; cs_rate = csr;
    aux_keep = nar; s_valid = 1'b1;
    while (1) begin
      #5;
      if (s_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk); #5;
      if (!rst && m_valid && m_ready) begin
        logic [23:0] e; string t;
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R2 unexpected output actual=%h expected=none", m_data);
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          total++;
          if (m_data !== e) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", t, m_data, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #5;
    total++;
    if (m_valid !== 1'b0 || s_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1 actual=%b%b expected=01", m_valid, s_ready);
    end

    // R3/R6: software bit off, bypass
    send(24'h123456, 3'd0, 0, 1, 2'd0, 1, 1, 2'd0, 0, "R3 bypass a");
    send(24'h800000, 3'd3, 0, 1, 2'd1, 1, 1, 2'd0, 0, "R3 bypass b");
    send(24'h7FFFFF, 3'd2, 0, 0, 2'd2, 0, 0, 2'd0, 1, "R3 bypass c");
    // R4/R5/R9: 44.1 impulse and step
    send(24'h400000, 3'd1, 1, 0, 2'd0, 0, 0, 2'd0, 0, "R4 R5 44k1 impulse");
    for (int i = 0; i < 4; i++)
      send(24'h000000, 3'd1, 1, 0, 2'd0, 0, 0, 2'd0, 0, "R4 R9 44k1 tail");
    for (int i = 0; i < 4; i++)
      send(24'hC00000, 3'd1, 1, 0, 2'd0, 0, 0, 2'd0, 0, "R4 R9 neg step");
    // R3: disable clears history, then re-enable
    send(24'h0ABCDE, 3'd1, 0, 0, 2'd0, 0, 0, 2'd0, 0, "R3 disabled");
    send(24'h300000, 3'd1, 1, 0, 2'd1, 0, 0, 2'd0, 0, "R3 R5 48k fresh");
    send(24'h300000, 3'd1, 1, 0, 2'd1, 0, 0, 2'd0, 0, "R5 48k");
    // R10: rate switch keeps history
    send(24'h300000, 3'd1, 1, 0, 2'd2, 0, 0, 2'd0, 0, "R10 R5 32k switch");
    send(24'hD00000, 3'd1, 1, 0, 2'd2, 0, 0, 2'd0, 0, "R5 32k");
    send(24'h100000, 3'd1, 1, 0, 2'd3, 0, 0, 2'd0, 0, "R7 code3 default");
    // R6: pin source
    send(24'h200000, 3'd5, 0, 1, 2'd0, 0, 0, 2'd0, 0, "R6 pin on");
    send(24'h200000, 3'd4, 1, 0, 2'd0, 0, 0, 2'd0, 0, "R6 pin off bypass");
    send(24'h654321, 3'd6, 1, 1, 2'd1, 0, 0, 2'd0, 0, "R6 pin mode6");
    // R7: channel-status source
    send(24'h111111, 3'd7, 1, 1, 2'd0, 1, 0, 2'd1, 0, "R7 cs emph off");
    send(24'h350000, 3'd7, 0, 0, 2'd0, 1, 1, 2'd1, 0, "R7 cs 48k");
    send(24'h350000, 3'd7, 0, 0, 2'd0, 1, 1, 2'd2, 0, "R7 R10 cs 32k");
    send(24'h222222, 3'd7, 1, 1, 2'd1, 0, 1, 2'd1, 0, "R7 cs invalid");
    send(24'h350000, 3'd7, 0, 0, 2'd2, 1, 1, 2'd3, 0, "R7 cs code3");
    // R8: narrow mode, low nibble kept, width change clears history
    send(24'h40000A, 3'd1, 1, 0, 2'd0, 0, 0, 2'd0, 1, "R8 narrow a");
    send(24'h000005, 3'd1, 1, 0, 2'd0, 0, 0, 2'd0, 1, "R8 narrow b");
    send(24'h80000F, 3'd1, 1, 0, 2'd2, 0, 0, 2'd0, 1, "R8 narrow c");
    send(24'h7FFFF3, 3'd1, 1, 0, 2'd1, 0, 0, 2'd0, 1, "R8 narrow d");
    send(24'h400000, 3'd1, 1, 0, 2'd0, 0, 0, 2'd0, 0, "R8 R9 back to wide");
    // R2: backpressure
    bp = 1'b1;
    for (int i = 0; i < 8; i++)
      send(24'h080000 * i, 3'd1, 1, 0, 2'(i % 3), 0, 0, 2'd0, i[2],
           "R2 backpressure");
    bp = 1'b0;
    repeat (40) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2 pending actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule